// File: doc/BRIEF.md
# Header-Relative Key Field Extractor

This block builds the user-defined part of a packet classifier key from a byte-wide frame stream. Each of its selector slots names a 16-bit field by a base (the end of the layer-2 header or the end of the layer-3 header) and a word index. As bytes go by, the block works out where each header ends and captures the chosen fields without buffering the frame. It also collects a word of parsed header flags.

Selectors live in one register bank per slice, and a slice is chosen per frame when the frame starts. When the last byte of a frame has been taken, the block presents every field, a valid bit per field and the flag word together, for one cycle. They are held until the next frame completes. A lookup stage downstream uses these values as the user-defined part of its search key.

Top module: `hdr_field_extract`

## Requirements
- R1: A selector byte holds a base code in bits [7:5] and a word index in bits [4:0]. Code 3'b010 measures from the end of L2 and code 3'b100 from the end of L3. The field is the big-endian pair of bytes at base + 2*index and base + 2*index + 1, and slot i appears at key_fields[16*i +: 16].
- R2: The end of L2 is byte 14 of the frame, plus 4 for each VLAN tag. A tag is recognised by type 0x8100 or 0x88A8, and at most two tags are taken. A third tag type is treated as the final ethertype.
- R3: For ethertype 0x0800 the end of L3 is the end of L2 plus 4 times the low nibble of the first IPv4 byte. For 0x86DD it is the end of L2 plus 40. For any other type, fields measured from the end of L3 are not valid.
- R4: A selector whose base code is neither 3'b010 nor 3'b100 leaves its slot unused: valid bit 0 and value 0. This includes a selector of zero.
- R5: A field whose second byte lies at or beyond the end of the frame has its valid bit 0 and its value 0.
- R6: A configuration write stores cfg_wdata at slice cfg_addr[7:6], slot cfg_addr[5:2]. A write naming a slot of 12 or more changes nothing. The slice used for a frame is key_slice, sampled on the start-of-frame byte.
- R7: The layer-3 framing code sits in flags [25:24] (00 IPv4, 01 IPv6, 11 other or unresolved). The IP protocol or next-header byte sits in [15:8], and the ToS or traffic class in [23:16]. All three are zero for non-IP frames.
- R8: Flag [7] (fragment) is set when the IPv4 more-fragments bit is set or the fragment offset is nonzero. Flag [6] (non-first fragment) is set when the offset is nonzero. Both are 0 for IPv6.
- R9: Flag [0] repeats the valid bit of slot 8. Flag bits [5:1] and [31:26] are 0.
- R10: After reset, key_valid and all key outputs are 0. key_valid is high for exactly the cycle after the end-of-frame byte is taken. The outputs change only together with key_valid.
- R11: A byte presented with s_valid high is ignored, and produces no key, unless it starts a frame (s_sop) or follows a start inside an unfinished frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Selector register write strobe |
| cfg_addr | input | 8 | Selector register byte address: slice [7:6], slot [5:2] |
| cfg_wdata | input | 8 | Selector byte to store |
| key_slice | input | 2 | Slice to apply, sampled on the start-of-frame byte |
| s_valid | input | 1 | Stream byte present |
| s_sop | input | 1 | Byte is the first of a frame |
| s_eop | input | 1 | Byte is the last of a frame |
| s_data | input | 8 | Stream byte |
| key_valid | output | 1 | Key outputs updated this cycle |
| key_fields | output | 192 | Twelve captured 16-bit fields, slot 0 in the low bits |
| key_field_valid | output | 12 | Per-slot valid bits |
| key_flags | output | 32 | Parsed header flags |

## Verification
The bench goes after the places where the header ends move. It uses zero, one and two VLAN tags, so a parser that ignored a tag would capture address bytes four off. It uses IPv4 headers with options, where a fixed 20-byte layer-3 offset would pick up option bytes instead of the ports. It sends a frame cut short in the middle of the destination address, where a design that did not clear partial captures would report half a field as valid. It also covers non-IP frames, which must leave every L3-relative slot invalid, and fragment words that set only the more-fragments bit or only the offset. Finally it checks a write to slot 12 that must not alias to a real slot, and stray bytes outside a frame, including a stray end-of-frame that must not raise key_valid.

// File: rtl/hfx_pkg.sv
package hfx_pkg;

    typedef enum logic [1:0] {
        L3_IPV4  = 2'b00,
        L3_IPV6  = 2'b01,
        L3_OTHER = 2'b11
    } l3_kind_e;

    // Selector base codes in bits [7:5]
    localparam logic [2:0] BASE_L2END = 3'b010;
    localparam logic [2:0] BASE_L3END = 3'b100;
    localparam int         SEL_IDX_W  = 5;

    localparam logic [15:0] TPID_CTAG  = 16'h8100;
    localparam logic [15:0] TPID_STAG  = 16'h88A8;
    localparam logic [15:0] ETYPE_IPV4 = 16'h0800;
    localparam logic [15:0] ETYPE_IPV6 = 16'h86DD;

    localparam int ETH_HDR_BYTES  = 14;
    localparam int VLAN_TAG_BYTES = 4;
    localparam int IPV6_HDR_BYTES = 40;

    // Flag word layout
    localparam int FLG_FRAMING_LSB = 24;
    localparam int FLG_TOS_LSB     = 16;
    localparam int FLG_PROTO_LSB   = 8;
    localparam int FLG_FRAG        = 7;
    localparam int FLG_NONFIRST    = 6;

endpackage

// File: rtl/hfx_sel_bank.sv
module hfx_sel_bank
    import hfx_pkg::*;
#(
    parameter int NUM_SLICES = 4,
    parameter int SLOTS      = 12,
    localparam int SLICE_W   = $clog2(NUM_SLICES),
    localparam int SLOT_W    = $clog2(SLOTS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [SLICE_W-1:0] wr_slice,
    input  logic [SLOT_W-1:0]  wr_slot,
    input  logic [7:0]         wr_data,
    input  logic [SLICE_W-1:0] rd_slice,
    output logic [SLOTS*8-1:0] rd_sel
);

    logic [NUM_SLICES-1:0][SLOTS-1:0][7:0] bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (wr_en && (int'(wr_slot) < SLOTS) && (int'(wr_slice) < NUM_SLICES)) begin
            bank_d[wr_slice][wr_slot] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign rd_sel = bank_q[rd_slice];

endmodule

// File: rtl/hfx_hdr_parse.sv
module hfx_hdr_parse
    import hfx_pkg::*;
#(
    parameter int CNT_W    = 11,
    parameter int MAX_TAGS = 2,
    localparam int TAG_W   = $clog2(MAX_TAGS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             s_valid,
    input  logic             s_sop,
    input  logic             s_eop,
    input  logic [7:0]       s_data,
    output logic             beat,
    output logic [CNT_W-1:0] cur_pos,
    output logic [CNT_W-1:0] l2_end,
    output logic             l2_known,
    output logic [CNT_W-1:0] l3_end,
    output logic             l3_known,
    output logic             key_valid,
    output logic [31:0]      flags
);

    localparam logic [CNT_W-1:0] POS_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] pos;
        logic             in_frame;
        logic [TAG_W-1:0] ntags;
        logic [7:0]       ety_hi;
        logic [CNT_W-1:0] l2_end;
        logic             l2_known;
        l3_kind_e         kind;
        logic [CNT_W-1:0] l3_end;
        logic             l3_known;
        logic [7:0]       tos;
        logic [7:0]       proto;
        logic             mf;
        logic [12:0]      foff;
        logic             key;
        logic [31:0]      flags;
    } parse_t;

    parse_t d, q;

    logic             beat_c;
    logic [CNT_W-1:0] cur_c;
    logic [CNT_W-1:0] etpos;
    logic [CNT_W-1:0] rel;
    logic [15:0]      ety;

    always_comb begin
        d      = q;
        d.key  = 1'b0;
        beat_c = s_valid && (s_sop || q.in_frame);
        cur_c  = s_sop ? '0 : q.pos;
        etpos  = '0;
        rel    = '0;
        ety    = '0;

        if (beat_c) begin
            if (s_sop) begin
                d.ntags    = '0;
                d.l2_end   = '0;
                d.l2_known = 1'b0;
                d.kind     = L3_OTHER;
                d.l3_end   = '0;
                d.l3_known = 1'b0;
                d.tos      = '0;
                d.proto    = '0;
                d.mf       = 1'b0;
                d.foff     = '0;
            end

            etpos = CNT_W'(ETH_HDR_BYTES - 2) + CNT_W'(d.ntags) * CNT_W'(VLAN_TAG_BYTES);

            if (!d.l2_known) begin
                // Walk the type fields until a non-tag type resolves L2
                if (cur_c == etpos) begin
                    d.ety_hi = s_data;
                end else if (cur_c == etpos + 1'b1) begin
                    ety = {d.ety_hi, s_data};
                    if ((ety == TPID_CTAG || ety == TPID_STAG) &&
                        (d.ntags < TAG_W'(MAX_TAGS))) begin
                        d.ntags = d.ntags + 1'b1;
                    end else begin
                        d.l2_known = 1'b1;
                        d.l2_end   = cur_c + 1'b1;
                        if (ety == ETYPE_IPV4) begin
                            d.kind = L3_IPV4;
                        end else if (ety == ETYPE_IPV6) begin
                            d.kind     = L3_IPV6;
                            d.l3_end   = cur_c + CNT_W'(1 + IPV6_HDR_BYTES);
                            d.l3_known = 1'b1;
                        end else begin
                            d.kind = L3_OTHER;
                        end
                    end
                end
            end else begin
                rel = cur_c - d.l2_end;
                if (d.kind == L3_IPV4) begin
                    if (rel == CNT_W'(0)) begin
                        d.l3_end   = d.l2_end + CNT_W'({s_data[3:0], 2'b00});
                        d.l3_known = 1'b1;
                    end
                    if (rel == CNT_W'(1)) d.tos = s_data;
                    if (rel == CNT_W'(6)) begin
                        d.mf         = s_data[5];
                        d.foff[12:8] = s_data[4:0];
                    end
                    if (rel == CNT_W'(7)) d.foff[7:0] = s_data;
                    if (rel == CNT_W'(9)) d.proto = s_data;
                end else if (d.kind == L3_IPV6) begin
                    if (rel == CNT_W'(0)) d.tos[7:4] = s_data[3:0];
                    if (rel == CNT_W'(1)) d.tos[3:0] = s_data[7:4];
                    if (rel == CNT_W'(6)) d.proto = s_data;
                end
            end

            d.pos      = (cur_c == POS_MAX) ? cur_c : cur_c + 1'b1;
            d.in_frame = !s_eop;

            if (s_eop) begin
                d.key                            = 1'b1;
                d.flags                          = '0;
                d.flags[FLG_FRAMING_LSB +: 2]    = d.kind;
                d.flags[FLG_TOS_LSB +: 8]        = d.tos;
                d.flags[FLG_PROTO_LSB +: 8]      = d.proto;
                d.flags[FLG_FRAG]                = d.mf || (|d.foff);
                d.flags[FLG_NONFIRST]            = |d.foff;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign beat      = beat_c;
    assign cur_pos   = cur_c;
    assign l2_end    = q.l2_end;
    assign l2_known  = q.l2_known;
    assign l3_end    = q.l3_end;
    assign l3_known  = q.l3_known;
    assign key_valid = q.key;
    assign flags     = q.flags;

endmodule

// File: rtl/hfx_field_cap.sv
module hfx_field_cap
    import hfx_pkg::*;
#(
    parameter int SLOTS = 12,
    parameter int CNT_W = 11
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                beat,
    input  logic                sop,
    input  logic                eop,
    input  logic [CNT_W-1:0]    cur_pos,
    input  logic [7:0]          data,
    input  logic [SLOTS*8-1:0]  sel,
    input  logic [CNT_W-1:0]    l2_end,
    input  logic                l2_known,
    input  logic [CNT_W-1:0]    l3_end,
    input  logic                l3_known,
    output logic [SLOTS*16-1:0] fields,
    output logic [SLOTS-1:0]    fvalid
);

    logic [SLOTS-1:0] hit_hi, hit_lo;

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        logic [2:0]           code;
        logic [SEL_IDX_W-1:0] idx;
        logic                 base_ok;
        logic [CNT_W-1:0]     base;
        logic [CNT_W-1:0]     tgt;

        assign code = sel[i*8+5 +: 3];
        assign idx  = sel[i*8 +: SEL_IDX_W];

        always_comb begin
            base    = '0;
            base_ok = 1'b0;
            if (code == BASE_L2END) begin
                base    = l2_end;
                base_ok = l2_known;
            end else if (code == BASE_L3END) begin
                base    = l3_end;
                base_ok = l3_known;
            end
        end

        assign tgt       = base + CNT_W'({idx, 1'b0});
        assign hit_hi[i] = beat && !sop && base_ok && (cur_pos == tgt);
        assign hit_lo[i] = beat && !sop && base_ok && (cur_pos == tgt + 1'b1);
    end

    typedef struct packed {
        logic [SLOTS-1:0][15:0] val;
        logic [SLOTS-1:0]       done;
        logic [SLOTS-1:0][15:0] fout;
        logic [SLOTS-1:0]       vout;
    } cap_t;

    cap_t d, q;

    always_comb begin
        d = q;
        if (beat && sop) begin
            d.val  = '0;
            d.done = '0;
        end
        for (int i = 0; i < SLOTS; i++) begin
            if (hit_hi[i]) d.val[i][15:8] = data;
            if (hit_lo[i]) begin
                d.val[i][7:0] = data;
                d.done[i]     = 1'b1;
            end
        end
        if (beat && eop) begin
            for (int i = 0; i < SLOTS; i++) begin
                d.vout[i] = d.done[i];
                d.fout[i] = d.done[i] ? d.val[i] : 16'h0000;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign fields = q.fout;
    assign fvalid = q.vout;

endmodule

// File: rtl/hdr_field_extract.sv
module hdr_field_extract
    import hfx_pkg::*;
#(
    parameter int NUM_SLICES = 4,
    parameter int SLOTS      = 12,
    parameter int CNT_W      = 11,
    parameter int MAX_TAGS   = 2,
    localparam int SLICE_W   = $clog2(NUM_SLICES),
    localparam int SLOT_W    = $clog2(SLOTS),
    localparam int ADDR_W    = SLICE_W + SLOT_W + 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [ADDR_W-1:0]   cfg_addr,
    input  logic [7:0]          cfg_wdata,
    input  logic [SLICE_W-1:0]  key_slice,
    input  logic                s_valid,
    input  logic                s_sop,
    input  logic                s_eop,
    input  logic [7:0]          s_data,
    output logic                key_valid,
    output logic [SLOTS*16-1:0] key_fields,
    output logic [SLOTS-1:0]    key_field_valid,
    output logic [31:0]         key_flags
);

    logic [SLICE_W-1:0] slice_d, slice_q;
    logic [SLOTS*8-1:0] cur_sel;
    logic               beat;
    logic [CNT_W-1:0]   cur_pos, l2_end, l3_end;
    logic               l2_known, l3_known;
    logic [31:0]        pflags;
    logic               udf_hi;

    always_comb begin
        slice_d = slice_q;
        if (s_valid && s_sop) slice_d = key_slice;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slice_q <= '0;
        end else begin
            slice_q <= slice_d;
        end
    end

    hfx_sel_bank #(
        .NUM_SLICES (NUM_SLICES),
        .SLOTS      (SLOTS)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_we),
        .wr_slice (cfg_addr[ADDR_W-1 -: SLICE_W]),
        .wr_slot  (cfg_addr[2 +: SLOT_W]),
        .wr_data  (cfg_wdata),
        .rd_slice (slice_d),
        .rd_sel   (cur_sel)
    );

    hfx_hdr_parse #(
        .CNT_W    (CNT_W),
        .MAX_TAGS (MAX_TAGS)
    ) u_parse (
        .clk       (clk),
        .rst_n     (rst_n),
        .s_valid   (s_valid),
        .s_sop     (s_sop),
        .s_eop     (s_eop),
        .s_data    (s_data),
        .beat      (beat),
        .cur_pos   (cur_pos),
        .l2_end    (l2_end),
        .l2_known  (l2_known),
        .l3_end    (l3_end),
        .l3_known  (l3_known),
        .key_valid (key_valid),
        .flags     (pflags)
    );

    hfx_field_cap #(
        .SLOTS (SLOTS),
        .CNT_W (CNT_W)
    ) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .beat     (beat),
        .sop      (s_sop),
        .eop      (s_eop),
        .cur_pos  (cur_pos),
        .data     (s_data),
        .sel      (cur_sel),
        .l2_end   (l2_end),
        .l2_known (l2_known),
        .l3_end   (l3_end),
        .l3_known (l3_known),
        .fields   (key_fields),
        .fvalid   (key_field_valid)
    );

    if (SLOTS > 8) begin : g_udf_hi
        assign udf_hi = key_field_valid[8];
    end else begin : g_no_udf_hi
        assign udf_hi = 1'b0;
    end

    assign key_flags = pflags | {31'b0, udf_hi};

endmodule

// File: rtl/hdr_field_extract_chk.sv
module hdr_field_extract_chk #(
    parameter int SLOTS = 12
) (
    input logic                clk,
    input logic                rst_n,
    input logic                s_valid,
    input logic                s_eop,
    input logic                key_valid,
    input logic [SLOTS*16-1:0] key_fields,
    input logic [SLOTS-1:0]    key_field_valid,
    input logic [31:0]         key_flags
);

    // R10
    key_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid |-> $past(s_valid && s_eop));

    // R10
    key_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !key_valid |-> ($stable(key_fields) && $stable(key_field_valid) && $stable(key_flags)));

    for (genvar i = 0; i < SLOTS; i++) begin : g_zero
        // R4 R5
        invalid_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !key_field_valid[i] |-> (key_fields[i*16 +: 16] == 16'h0000));
    end

    // R7
    framing_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid |-> (key_flags[25:24] != 2'b10));

    // R8
    nonfirst_frag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (key_valid && key_flags[6]) |-> key_flags[7]);

    // R9
    flag_spare_chk: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid |-> ((key_flags[5:1] == 5'b0) && (key_flags[31:26] == 6'b0)));

endmodule

bind hdr_field_extract hdr_field_extract_chk #(.SLOTS(SLOTS)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .s_valid         (s_valid),
    .s_eop           (s_eop),
    .key_valid       (key_valid),
    .key_fields      (key_fields),
    .key_field_valid (key_field_valid),
    .key_flags       (key_flags)
);

// File: tb/hdr_field_extract_test.sv
module hdr_field_extract_test;

    localparam int SLOTS = 12;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_we = 1'b0;
    logic [7:0]   cfg_addr = '0;
    logic [7:0]   cfg_wdata = '0;
    logic [1:0]   key_slice = '0;
    logic         s_valid = 1'b0;
    logic         s_sop = 1'b0;
    logic         s_eop = 1'b0;
    logic [7:0]   s_data = '0;
    logic         key_valid;
    logic [191:0] key_fields;
    logic [11:0]  key_field_valid;
    logic [31:0]  key_flags;

    always #5 clk = ~clk;

    hdr_field_extract uut (
        .clk             (clk),
        .rst_n           (rst_n),
        .cfg_we          (cfg_we),
        .cfg_addr        (cfg_addr),
        .cfg_wdata       (cfg_wdata),
        .key_slice       (key_slice),
        .s_valid         (s_valid),
        .s_sop           (s_sop),
        .s_eop           (s_eop),
        .s_data          (s_data),
        .key_valid       (key_valid),
        .key_fields      (key_fields),
        .key_field_valid (key_field_valid),
        .key_flags       (key_flags)
    );

    typedef struct {
        logic [191:0] f;
        logic [11:0]  v;
        logic [31:0]  fl;
        string        tag;
    } exp_t;

    exp_t       sb[$];
    int         n_run = 0;
    int         n_fail = 0;
    logic [7:0] frm [0:127];
    int         flen;
    logic [7:0] selm [0:3][0:11];

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [191:0] act, input logic [191:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    // Reference model built from the requirements
    function automatic exp_t model(input int sl, input string tag);
        exp_t e;
        int ntags, p, l2e, l3e, kind, tos, proto, mf, foff, ety, code, idx, base;
        ntags = 0; p = 12; l2e = -1; ety = 0;
        while (p + 1 < flen) begin
            ety = {frm[p], frm[p+1]};
            if ((ety == 16'h8100 || ety == 16'h88A8) && ntags < 2) begin
                ntags++;
                p += 4;
            end else begin
                l2e = p + 2;
                break;
            end
        end
        kind = 3; l3e = -1; tos = 0; proto = 0; mf = 0; foff = 0;
        if (l2e >= 0) begin
            if (ety == 16'h0800) begin
                kind = 0;
                if (l2e < flen) l3e = l2e + 4 * (frm[l2e] & 15);
                if (l2e + 1 < flen) tos = frm[l2e+1];
                if (l2e + 6 < flen) begin
                    mf = frm[l2e+6][5];
                    foff = (frm[l2e+6] & 31) << 8;
                end
                if (l2e + 7 < flen) foff = foff | frm[l2e+7];
                if (l2e + 9 < flen) proto = frm[l2e+9];
            end else if (ety == 16'h86DD) begin
                kind = 1;
                l3e = l2e + 40;
                if (l2e < flen) tos = (frm[l2e] & 15) << 4;
                if (l2e + 1 < flen) tos = tos | (frm[l2e+1] >> 4);
                if (l2e + 6 < flen) proto = frm[l2e+6];
            end
        end
        e.f = '0; e.v = '0; e.tag = tag;
        for (int i = 0; i < SLOTS; i++) begin
            code = selm[sl][i] >> 5;
            idx  = selm[sl][i] & 31;
            base = (code == 2) ? l2e : (code == 4) ? l3e : -1;
            if (base >= 0 && base + 2 * idx + 1 < flen) begin
                e.v[i] = 1'b1;
                e.f[i*16 +: 16] = {frm[base+2*idx], frm[base+2*idx+1]};
            end
        end
        e.fl = (32'(kind) << 24) | (32'(tos) << 16) | (32'(proto) << 8) |
               (32'((mf != 0) || (foff != 0)) << 7) | (32'(foff != 0) << 6) |
               32'(e.v[8]);
        return e;
    endfunction

    task automatic cfg_wr(input int sl, input int slot, input logic [7:0] val);
        cfg_we    = 1'b1;
        cfg_addr  = {2'(sl), 4'(slot), 2'b00};
        cfg_wdata = val;
        @(posedge clk); #1;
        cfg_we = 1'b0;
        if (slot < SLOTS) selm[sl][slot] = val;
    endtask

    task automatic clr_frame();
        for (int k = 0; k < 128; k++) frm[k] = 8'(k * 7 + 3);
    endtask

    task automatic mk_ipv4(input int ntag, input int ihl, input int proto,
                           input int fragw, input int paylen);
        int p, l2, l3;
        clr_frame();
        p = 12;
        for (int t = 0; t < ntag; t++) begin
            {frm[p], frm[p+1]} = (ntag == 2 && t == 0) ? 16'h88A8 : 16'h8100;
            {frm[p+2], frm[p+3]} = 16'(100 + t);
            p += 4;
        end
        {frm[p], frm[p+1]} = 16'h0800;
        l2 = p + 2;
        frm[l2]   = 8'(8'h40 | ihl);
        frm[l2+1] = 8'h2E;
        {frm[l2+6], frm[l2+7]} = 16'(fragw);
        frm[l2+9] = 8'(proto);
        {frm[l2+12], frm[l2+13], frm[l2+14], frm[l2+15]} = 32'hC0A8010A;
        {frm[l2+16], frm[l2+17], frm[l2+18], frm[l2+19]} = 32'h0A000005;
        for (int k = l2 + 20; k < l2 + 4 * ihl; k++) frm[k] = 8'hEE;
        l3 = l2 + 4 * ihl;
        {frm[l3], frm[l3+1]}   = 16'h1F90;
        {frm[l3+2], frm[l3+3]} = 16'hC350;
        flen = l3 + 4 + paylen;
    endtask

    task automatic mk_ipv6(input int proto);
        clr_frame();
        {frm[12], frm[13]} = 16'h86DD;
        frm[14] = 8'h6A;
        frm[15] = 8'hB0;
        frm[20] = 8'(proto);
        for (int k = 0; k < 16; k++) frm[22+k] = 8'(8'h20 + k);
        for (int k = 0; k < 16; k++) frm[38+k] = 8'(8'h80 + k);
        {frm[54], frm[55]} = 16'h0BB8;
        {frm[56], frm[57]} = 16'h0050;
        flen = 62;
    endtask

    task automatic send(input int sl, input string tag, input bit gap);
        sb.push_back(model(sl, tag));
        for (int k = 0; k < flen; k++) begin
            s_valid   = 1'b1;
            s_sop     = (k == 0);
            s_eop     = (k == flen - 1);
            s_data    = frm[k];
            key_slice = 2'(sl);
            @(posedge clk); #1;
            if (gap && k == 5) begin
                s_valid = 1'b0;
                repeat (2) @(posedge clk);
                #1;
            end
        end
        s_valid = 1'b0; s_sop = 1'b0; s_eop = 1'b0;
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && key_valid) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R11", "unexpected key", 192'(key_valid), 192'(0));
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(key_fields == e.f, e.tag, "fields", key_fields, e.f);
                chk(key_field_valid == e.v, e.tag, "valid", 192'(key_field_valid), 192'(e.v));
                chk(key_flags == e.fl, e.tag, "flags", 192'(key_flags), 192'(e.fl));
            end
        end
    end

    bit finished = 1'b0;

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog act=running exp=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        for (int s = 0; s < 4; s++) for (int i = 0; i < SLOTS; i++) selm[s][i] = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10 reset state
        chk(key_valid == 1'b0, "R10", "reset key_valid", 192'(key_valid), 192'(0));
        chk(key_fields == '0, "R10", "reset fields", key_fields, 192'(0));
        chk(key_field_valid == '0 && key_flags == '0, "R10", "reset valid/flags",
            192'({key_field_valid, key_flags}), 192'(0));
        @(posedge clk); #1;
        rst_n = 1'b1;
        @(posedge clk); #1;

        // Slice 0: IPv4 addresses from L2 end, ports from L3 end
        cfg_wr(0, 0, 8'h46); cfg_wr(0, 1, 8'h47); cfg_wr(0, 2, 8'h48);
        cfg_wr(0, 3, 8'h49); cfg_wr(0, 4, 8'h80); cfg_wr(0, 5, 8'h81);
        // Slice 1: IPv6 source words and source port
        for (int i = 0; i < 8; i++) cfg_wr(1, i, 8'(8'h44 + i));
        cfg_wr(1, 8, 8'h80);
        // Slice 2: IPv6 destination words and destination port
        for (int i = 0; i < 8; i++) cfg_wr(2, i, 8'(8'h4C + i));
        cfg_wr(2, 8, 8'h81);
        // Slice 3: bad codes, far index, one good slot, and an out-of-range slot write
        cfg_wr(3, 0, 8'h26); cfg_wr(3, 1, 8'hC5); cfg_wr(3, 2, 8'h5F);
        cfg_wr(3, 3, 8'h41); cfg_wr(3, 12, 8'h46);

        mk_ipv4(0, 5, 6, 16'h4000, 6);  send(0, "R1", 1'b0);
        mk_ipv4(0, 7, 17, 0, 4);        send(0, "R3", 1'b0);
        mk_ipv4(1, 5, 6, 0, 2);         send(0, "R2", 1'b0);
        mk_ipv4(2, 5, 17, 0, 2);        send(0, "R2", 1'b0);
        mk_ipv4(0, 5, 6, 16'h2000, 2);  send(0, "R8", 1'b0);
        mk_ipv4(0, 5, 6, 16'h0010, 2);  send(0, "R8", 1'b0);
        mk_ipv6(6);                     send(1, "R9", 1'b0);
        mk_ipv6(17);                    send(2, "R7", 1'b0);
        clr_frame(); {frm[12], frm[13]} = 16'h0806; flen = 60;
        send(0, "R3", 1'b0);
        mk_ipv4(0, 5, 6, 0, 2); flen = 31;
        send(0, "R5", 1'b0);
        mk_ipv4(0, 5, 6, 0, 2);         send(3, "R4 R6", 1'b0);

        // Stray bytes outside a frame, ending in a stray end-of-frame
        for (int k = 0; k < 4; k++) begin
            s_valid = 1'b1; s_sop = 1'b0; s_eop = (k == 3); s_data = 8'h81;
            @(posedge clk); #1;
        end
        s_valid = 1'b0; s_eop = 1'b0;
        mk_ipv4(1, 5, 6, 0, 2);         send(0, "R11", 1'b0);

        // Back-to-back frames, then one with idle gaps
        mk_ipv4(0, 6, 17, 0, 0);        send(0, "R10", 1'b0);
        mk_ipv6(6);                     send(1, "R10", 1'b0);
        mk_ipv4(2, 5, 6, 16'h2001, 3);  send(0, "R10", 1'b1);

        repeat (20) @(posedge clk);
        @(negedge clk);
        chk(sb.size() == 0, "R10", "keys outstanding", 192'(sb.size()), 192'(0));
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule